// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 34-bit physical address by walking a two-level page table held in memory. A requester gives a virtual address together with the access kind (load, store or fetch), the privilege of the access, two permission modifiers and the physical page number of the root table. The walker then reads 4-byte table entries over a simple request/response memory port, one entry per level. It stops at the first leaf entry, or at the first fault.

When a leaf allows the access, the walker may need to set the entry's accessed and dirty flags. If hardware update is enabled, it writes the modified entry back to the address it was read from. If update is disabled, the access is refused with its own fault code. Superpage leaves found at the upper level are checked for alignment and are completed with the lower virtual page bits. The global attribute is collected along the path. Each request ends in exactly one response: either a physical address with its level and global flag, or a fault code.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: The first entry is read at `{req_root_ppn,12'b0} + 4*vaddr[31:22]`. The second-level entry is read at `next_base + 4*vaddr[21:12]`. Every memory access is a single-cycle `mem_req` pulse to a word-aligned address.
- R3: A memory error on an entry read ends the walk with fault code 1 (access).
- R4: Entry bits are V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7, and the PPN is bits 31:10. An entry with V=0, or with W=1 and R=0, gives fault code 2 (invalid). A pointer entry (R=0 and X=0) at level 0 also gives fault code 2.
- R5: A pointer entry at level 1 makes the walk continue at level 0. The next table base is the entry's PPN shifted left by 12.
- R6: A leaf fails with fault code 3 (permission) when any of these holds: a load sees R=0, unless X=1 and `req_exec_rd` is set; a store sees W=0; a fetch sees X=0; a user access (`req_user`=1) sees U=0; a supervisor access sees U=1 and either `req_sup_user` is 0 or the access is a fetch. Access encoding: 0 load, 1 store, 2 fetch.
- R7: A leaf at level 1 whose PPN bits 9:0 are not all zero gives fault code 4 (misaligned superpage).
- R8: On success (fault 0), a level-0 leaf gives `{PPN, vaddr[11:0]}`. A level-1 leaf gives `{PPN[21:10], vaddr[21:0]}`. `rsp_level` reports the leaf level.
- R9: `rsp_global` is the OR of the G bits of all entries read during the walk.
- R10: A permitted leaf that needs an update (A=0, or a store with D=0) gives fault code 5 when `upd_en` was 0 at acceptance. In that case no write is issued.
- R11: With update enabled, the entry is written back with A set, and with D also set on a store. A write error gives fault code 1. No write is issued when no update is needed.
- R12: A request is accepted only while `req_ready` is 1. Requests offered while busy are ignored. Each accepted request yields exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 for user privilege, 0 for supervisor |
| req_exec_rd | input | 1 | Loads may read execute-only pages |
| req_sup_user | input | 1 | Supervisor may load/store user pages |
| req_root_ppn | input | 22 | Root table physical page number |
| upd_en | input | 1 | Hardware accessed/dirty update enabled |
| mem_req | output | 1 | Memory access pulse |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 34 | Entry physical address |
| mem_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_err | input | 1 | Memory response reports an error |
| mem_rdata | input | 32 | Entry value read |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_fault | output | 3 | 0 ok, 1 access, 2 invalid, 3 permission, 4 misaligned, 5 update |
| rsp_paddr | output | 34 | Physical address (meaningful when fault is 0) |
| rsp_level | output | 1 | Level of the leaf |
| rsp_global | output | 1 | Global attribute of the path |

## Verification
The assertions assume that the memory answers each `mem_req` pulse with exactly one `mem_rsp_valid` pulse, at least one cycle later. They also assume that `mem_rdata` and `mem_rsp_err` are meaningful only in that response cycle. The bench memory model issues its response two cycles after it sees a request, and never more than one outstanding, so it stays inside this contract. Request inputs are held only for the acceptance cycle. The single stray request that is offered mid-walk serves to show that busy-time requests are dropped.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_acc,
  input  logic        req_user,
  input  logic        req_exec_rd,
  input  logic        req_sup_user,
  input  logic [21:0] req_root_ppn,
  input  logic        upd_en,
  output logic        mem_req,
  output logic        mem_we,
  output logic [33:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rsp_valid,
  input  logic        mem_rsp_err,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic [2:0]  rsp_fault,
  output logic [33:0] rsp_paddr,
  output logic        rsp_level,
  output logic        rsp_global
);
  localparam logic [1:0] ACC_LD = 2'd0, ACC_ST = 2'd1, ACC_EX = 2'd2;
  localparam logic [2:0] F_OK = 3'd0, F_ACC = 3'd1, F_INV = 3'd2,
                         F_PERM = 3'd3, F_MIS = 3'd4, F_UPD = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RDW, S_WR, S_WRW, S_DONE} st_t;
  st_t st;

  logic [21:0] va_q;
  logic [1:0]  acc_q;
  logic        user_q, xrd_q, suok_q, upd_q, lvl_q, glb_q;
  logic [33:0] pte_addr_q, paddr_q;
  logic [31:0] wdata_q;
  logic [2:0]  fault_q;

  wire e_v = mem_rdata[0];
  wire e_r = mem_rdata[1];
  wire e_w = mem_rdata[2];
  wire e_x = mem_rdata[3];
  wire e_u = mem_rdata[4];
  wire e_g = mem_rdata[5];
  wire e_a = mem_rdata[6];
  wire e_d = mem_rdata[7];

  wire is_store = (acc_q == ACC_ST);
  wire bad_ent  = !e_v || (e_w && !e_r);
  wire ptr_ent  = !e_r && !e_x;
  wire misalign = lvl_q && (mem_rdata[19:10] != 10'd0);
  wire need_upd = !e_a || (is_store && !e_d);

  logic kind_ok;
  always_comb begin
    case (acc_q)
      ACC_LD:  kind_ok = e_r || (xrd_q && e_x);
      ACC_ST:  kind_ok = e_w;
      ACC_EX:  kind_ok = e_x;
      default: kind_ok = 1'b0;
    endcase
  end
  wire priv_ok = user_q ? e_u : (!e_u || (suok_q && acc_q != ACC_EX));
  wire perm_ok = kind_ok && priv_ok;

  wire [33:0] leaf_pa  = lvl_q ? {mem_rdata[31:20], va_q[21:0]}
                               : {mem_rdata[31:10], va_q[11:0]};
  wire [33:0] next_ptr = {mem_rdata[31:10], 12'd0} + {20'd0, va_q[21:12], 2'b00};
  wire [31:0] upd_pte  = mem_rdata | 32'h40 | (is_store ? 32'h80 : 32'h0);

  assign req_ready  = (st == S_IDLE);
  assign mem_req    = (st == S_RD) || (st == S_WR);
  assign mem_we     = (st == S_WR);
  assign mem_addr   = pte_addr_q;
  assign mem_wdata  = wdata_q;
  assign rsp_valid  = (st == S_DONE);
  assign rsp_fault  = fault_q;
  assign rsp_paddr  = paddr_q;
  assign rsp_level  = lvl_q;
  assign rsp_global = glb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0; acc_q <= '0; user_q <= 1'b0; xrd_q <= 1'b0; suok_q <= 1'b0;
      upd_q <= 1'b0; lvl_q <= 1'b0; glb_q <= 1'b0;
      pte_addr_q <= '0; paddr_q <= '0; wdata_q <= '0; fault_q <= F_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr[21:0];
          acc_q   <= req_acc;
          user_q  <= req_user;
          xrd_q   <= req_exec_rd;
          suok_q  <= req_sup_user;
          upd_q   <= upd_en;
          lvl_q   <= 1'b1;
          glb_q   <= 1'b0;
          fault_q <= F_OK;
          paddr_q <= '0;
          pte_addr_q <= {req_root_ppn, 12'd0} + {20'd0, req_vaddr[31:22], 2'b00};
          st <= S_RD;
        end
        S_RD: st <= S_RDW;
        S_RDW: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            fault_q <= F_ACC;
            st <= S_DONE;
          end else begin
            glb_q <= glb_q | e_g;
            if (bad_ent) begin
              fault_q <= F_INV;
              st <= S_DONE;
            end else if (ptr_ent) begin
              if (!lvl_q) begin
                fault_q <= F_INV;
                st <= S_DONE;
              end else begin
                lvl_q <= 1'b0;
                pte_addr_q <= next_ptr;
                st <= S_RD;
              end
            end else if (!perm_ok) begin
              fault_q <= F_PERM;
              st <= S_DONE;
            end else if (misalign) begin
              fault_q <= F_MIS;
              st <= S_DONE;
            end else if (need_upd && !upd_q) begin
              fault_q <= F_UPD;
              st <= S_DONE;
            end else begin
              paddr_q <= leaf_pa;
              if (need_upd) begin
                wdata_q <= upd_pte;
                st <= S_WR;
              end else begin
                st <= S_DONE;
              end
            end
          end
        end
        S_WR: st <= S_WRW;
        S_WRW: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            fault_q <= F_ACC;
            paddr_q <= '0;
          end
          st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r12_no_rsp_while_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !rsp_valid);
  a_r2_mem_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  a_r10_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> upd_q);
  a_r11_write_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[6] && mem_wdata[0]));
  a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == F_OK) |-> (rsp_paddr[11:0] == va_q[11:0]));
  a_r3_fault_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= F_UPD));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_user, req_exec_rd, req_sup_user, upd_en;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic [21:0] req_root_ppn;
  logic        mem_req, mem_we, mem_rsp_valid, mem_rsp_err;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        rsp_valid, rsp_level, rsp_global;
  logic [2:0]  rsp_fault;
  logic [33:0] rsp_paddr;

  pt_walker uut (.*);

  int nchk = 0, nerr = 0;
  logic [31:0] mem [logic [33:0]];
  logic [33:0] err_rd = '1, err_wr = '1;
  logic [33:0] rd_log [4];
  int nrd = 0, nwr = 0, rsp_cnt = 0, pend = 0;
  logic [33:0] p_addr;
  logic        p_we;
  logic [31:0] p_wd;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    if (rsp_valid) rsp_cnt++;
    if (mem_req) begin
      p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata; pend = 2;
      if (mem_we) nwr++;
      else if (nrd < 4) begin rd_log[nrd] = mem_addr; nrd++; end
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rsp_valid = 1'b1;
        if (p_we) begin
          if (p_addr == err_wr) mem_rsp_err = 1'b1;
          else mem[p_addr] = p_wd;
        end else begin
          if (p_addr == err_rd) mem_rsp_err = 1'b1;
          else mem_rdata = mem.exists(p_addr) ? mem[p_addr] : 32'h0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(input logic [21:0] ppn, input logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction

  localparam logic [21:0] ROOT = 22'h00100;
  function automatic logic [33:0] root_slot(input int idx);
    return {ROOT, 12'd0} + 34'(idx * 4);
  endfunction

  logic [2:0]  r_fault;
  logic [33:0] r_pa;
  logic        r_lvl, r_glb;

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                      input logic xrd, input logic sok, input logic upd);
    @(negedge clk);
    req_vaddr = va; req_acc = acc; req_user = usr; req_exec_rd = xrd;
    req_sup_user = sok; upd_en = upd; req_root_ppn = ROOT; req_valid = 1'b1;
    nrd = 0; nwr = 0; rsp_cnt = 0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 60 && !rsp_valid; i++) @(negedge clk);
    r_fault = rsp_fault; r_pa = rsp_paddr; r_lvl = rsp_level; r_glb = rsp_global;
    if (!rsp_valid) chk("R12 response timeout", 0, 1);
    repeat (4) @(negedge clk);
  endtask

  task t_reset;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_req", mem_req, 0);
  endtask

  task t_small_page;
    walk({10'd3, 10'd5, 12'h123}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2 first read addr", rd_log[0], root_slot(3));
    chk("R5 second read addr", rd_log[1], 34'h0_0020_0014);
    chk("R8 fault", r_fault, 0);
    chk("R8 paddr", r_pa, {22'h12345, 12'h123});
    chk("R8 level", r_lvl, 0);
    chk("R9 global from pointer", r_glb, 1);
    chk("R11 no write when flags set", nwr, 0);
    chk("R12 one response", rsp_cnt, 1);
  endtask

  task t_superpage_store;
    logic [31:0] va;
    va = {10'd7, 10'h2A5, 12'hABC};
    walk(va, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 super fault", r_fault, 0);
    chk("R8 super paddr", r_pa, {12'h3C0, va[21:0]});
    chk("R8 super level", r_lvl, 1);
    chk("R9 global clear", r_glb, 0);
    chk("R11 one write", nwr, 1);
    chk("R11 dirty written", mem[root_slot(7)], ent({12'h3C0, 10'h0}, 8'hC7));
  endtask

  task t_misaligned;
    walk({10'd8, 10'd1, 12'h0}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 misaligned", r_fault, 4);
  endtask

  task t_invalid;
    walk({10'd9, 10'd0, 12'h0}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 V=0", r_fault, 2);
    walk({10'd10, 10'd0, 12'h0}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 W without R", r_fault, 2);
    walk({10'd11, 10'd0, 12'h0}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 pointer at level 0", r_fault, 2);
    chk("R4 two reads", nrd, 2);
  endtask

  task t_perms;
    walk({10'd12, 10'd0, 12'h4}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 sup load user page", r_fault, 3);
    walk({10'd12, 10'd0, 12'h4}, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 sup load user page allowed", r_fault, 0);
    walk({10'd12, 10'd0, 12'h4}, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R6 user load", r_fault, 0);
    walk({10'd12, 10'd0, 12'h4}, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R6 store read-only", r_fault, 3);
    chk("R6 no write on fault", nwr, 0);
    walk({10'd13, 10'd0, 12'h4}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 load exec-only", r_fault, 3);
    walk({10'd13, 10'd0, 12'h4}, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R6 load exec-only readable", r_fault, 0);
    walk({10'd13, 10'd0, 12'h4}, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R6 user fetch sup page", r_fault, 3);
    walk({10'd15, 10'd0, 12'h4}, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 sup fetch user page", r_fault, 3);
  endtask

  task t_update;
    walk({10'd14, 10'd0, 12'h8}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 update disabled", r_fault, 5);
    chk("R10 no write", nwr, 0);
    chk("R10 entry kept", mem[root_slot(14)], ent({12'h005, 10'h0}, 8'h03));
    walk({10'd14, 10'd0, 12'h8}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R11 update ok", r_fault, 0);
    chk("R11 accessed written", mem[root_slot(14)], ent({12'h005, 10'h0}, 8'h43));
  endtask

  task t_errors;
    err_rd = root_slot(16);
    walk({10'd16, 10'd0, 12'h0}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 read error", r_fault, 1);
    err_rd = '1;
    err_wr = root_slot(17);
    walk({10'd17, 10'd0, 12'h0}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R11 write error", r_fault, 1);
    chk("R11 write attempted", nwr, 1);
    err_wr = '1;
  endtask

  task t_busy_ignored;
    @(negedge clk);
    req_vaddr = {10'd3, 10'd5, 12'h456}; req_acc = 2'd0; req_user = 1'b0;
    req_exec_rd = 1'b0; req_sup_user = 1'b0; upd_en = 1'b1; req_valid = 1'b1;
    rsp_cnt = 0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 busy not ready", req_ready, 0);
    req_vaddr = {10'd8, 10'd0, 12'h0}; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 60 && !rsp_valid; i++) @(negedge clk);
    chk("R12 first request result", rsp_paddr, {22'h12345, 12'h456});
    repeat (20) @(negedge clk);
    chk("R12 stray request dropped", rsp_cnt, 1);
    chk("R12 idle again", req_ready, 1);
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_user = 1'b0;
    req_exec_rd = 1'b0; req_sup_user = 1'b0; req_root_ppn = ROOT; upd_en = 1'b0;
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rdata = '0;
    mem[root_slot(3)]  = ent(22'h00200, 8'h21);
    mem[34'h0_0020_0014] = ent(22'h12345, 8'h43);
    mem[root_slot(7)]  = ent({12'h3C0, 10'h0}, 8'h47);
    mem[root_slot(8)]  = ent({12'h001, 10'h004}, 8'h43);
    mem[root_slot(9)]  = 32'h0000_0042;
    mem[root_slot(10)] = ent({12'h002, 10'h0}, 8'h45);
    mem[root_slot(11)] = ent(22'h00300, 8'h01);
    mem[34'h0_0030_0000] = ent(22'h00005, 8'h01);
    mem[root_slot(12)] = ent({12'h004, 10'h0}, 8'h53);
    mem[root_slot(13)] = ent({12'h006, 10'h0}, 8'h49);
    mem[root_slot(14)] = ent({12'h005, 10'h0}, 8'h03);
    mem[root_slot(15)] = ent({12'h007, 10'h0}, 8'h5B);
    mem[root_slot(17)] = ent({12'h008, 10'h0}, 8'h03);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_small_page;
    t_superpage_store;
    t_misaligned;
    t_invalid;
    t_perms;
    t_update;
    t_errors;
    t_busy_ignored;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule